// File: doc/BRIEF.md
# In-Band Interrupt Status Sequence Aggregator

This block sits behind the status ring of an in-band-interrupt receive path. Status words arrive one at a time over a valid/ready handshake. Each word describes part of one interrupt event, and the block merges the consecutive words of that event into a single event record. The record gives the target address, the total payload length in bytes, the number of data chunks the payload occupies, an error flag and an oversize flag.

While it does this, the block keeps three pieces of ring bookkeeping for the software that drains the data chunk pool:

- a dequeue position for the status ring,
- a circular pointer into the chunk pool,
- a free-chunk credit count that grows by the chunks of each finished event.

Configuration is given on plain inputs and is changed only while reset is held:

- `cfg_ring_size`: the status ring size,
- `cfg_chunk_code`: the chunk size code,
- `cfg_pool_size`: the pool size in chunks,
- `cfg_max_bytes`: the largest payload accepted without flagging it.

Status word layout (32 bits):

| Bits | Field |
|------|-------|
| 31 | error flag |
| 30 | last-word flag |
| 29:23 | target address |
| 22:16 | chunk count |
| 15:0 | exact data length (meaningful on the last word) |

Top module: `ibi_seq_agg`

## Requirements
- R1: During reset `st_ready` is 0. From the first clock after reset it is 1. After reset `ev_valid`, `chunk_ptr`, `chunk_credit` and `status_deq_ptr` are all 0.
- R2: The chunk size in bytes is 2^(`cfg_chunk_code`+2) for codes 0 to 6, so 4 to 256 bytes. Code 7 is clamped to 256 bytes.
- R3: Each accepted word whose bit 30 is clear adds (bits 22:16) times the chunk size to the group's byte total. The word with bit 30 set adds its bits 15:0 instead. `ev_bytes` reports the total.
- R4: A group ends with the first accepted word that has bit 30 set. `ev_valid` is 1 for exactly the one cycle after the clock edge that accepted that word. While no such word has been accepted, `ev_valid` stays 0, including across idle cycles.
- R5: The first word of a group with bit 31 clear sets `ev_addr` from its bits 29:23. A later word that has bit 31 clear and a different address sets `ev_error`. A group in which no such word arrives reports address 0.
- R6: A word with bit 31 set latches `ev_error` for its group. After an error is latched, later words of the group do not change the address or the error state.
- R7: `ev_chunks` is the sum of bits 22:16 over all words of the group. At each event `chunk_ptr` becomes (`chunk_ptr` + that sum) modulo `cfg_pool_size`. A pool size of 0 keeps the pointer at 0.
- R8: At each event `chunk_credit` grows by `ev_chunks`, wrapping modulo 2^CREDIT_W.
- R9: `status_deq_ptr` changes only at an event. It then holds the ring position after the group's last word, counting one position per accepted word modulo `cfg_ring_size`; a ring size of 0 keeps it at 0.
- R10: `ev_oversize` is 1 exactly when `ev_bytes` is greater than `cfg_max_bytes`. A total equal to the limit is not oversize.
- R11: After an event the next word starts a clean group with no error, no address and zero totals, even when it arrives in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Status word offered |
| st_ready | output | 1 | Block accepts a status word |
| st_word | input | 32 | Status word |
| cfg_ring_size | input | RING_W | Status ring entries |
| cfg_chunk_code | input | 3 | Chunk size code |
| cfg_pool_size | input | POOL_W | Chunks in the data pool |
| cfg_max_bytes | input | BYTE_W | Payload size limit |
| ev_valid | output | 1 | Event record valid (one cycle) |
| ev_addr | output | 7 | Event target address |
| ev_bytes | output | BYTE_W | Event payload byte count |
| ev_chunks | output | SUM_W | Chunks used by the event |
| ev_error | output | 1 | Event had an error or an address change |
| ev_oversize | output | 1 | Byte count above the limit |
| chunk_ptr | output | POOL_W | Circular chunk pool pointer |
| chunk_credit | output | CREDIT_W | Free-chunk credit count |
| status_deq_ptr | output | RING_W | Status ring dequeue position |

## Verification
The bench goes after the following corner cases and the failure each would expose:

- **Error followed by words with clean flags.** A design that keeps evaluating addresses after an error would pick up a late address instead of reporting 0.
- **Address change after the address is fixed.** A design that overwrites the address would hide the mismatch.
- **Pending group across idle cycles.** A design that ends a group on a gap would emit early.
- **Back-to-back single-word groups.** A design that forgets to clear its state would leak an error or totals into the next event.
- **Payload exactly at the limit.** An off-by-one comparison would flag it as oversize.
- **Every chunk size code, including the clamped one.** A shift width error would give a wrong size for code 6 or code 7.
- **Pool and ring sizes that wrap often, or are zero, and a credit count run past its wrap.** A design that reduces the pointer by a single subtraction would go outside the pool on large chunk sums.

// File: rtl/ibi_agg_pkg.sv
// Package: field layout of an in-band-interrupt status word, the decoded
// word type and the chunk size rule shared by the aggregator modules.
// Assumes a fixed 32-bit status word.
package ibi_agg_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ERR_BIT  = 31;
    localparam int unsigned LAST_BIT = 30;
    localparam int unsigned ADDR_LSB = 23;
    localparam int unsigned ADDR_W   = 7;
    localparam int unsigned CHK_LSB  = 16;
    localparam int unsigned CHK_W    = 7;
    localparam int unsigned LEN_LSB  = 0;
    localparam int unsigned LEN_W    = 16;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned CSIZE_W  = 9;   // holds up to 256
    localparam logic [CODE_W-1:0] CODE_MAX = 3'd6;

    typedef struct packed {
        logic              err;
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic [CHK_W-1:0]  chunks;
        logic [LEN_W-1:0]  len;
    } ibi_word_t;

    // Chunk size in bytes from the size code, clamped at 256 bytes.
    function automatic logic [CSIZE_W-1:0] chunk_bytes(input logic [CODE_W-1:0] code);
        logic [3:0] sh;
        if (code > CODE_MAX) begin
            sh = 4'd8;
        end else begin
            sh = {1'b0, code} + 4'd2;
        end
        return CSIZE_W'(1) << sh;
    endfunction

endpackage

// File: rtl/ibi_word_decode.sv
// Module: splits a status word into its fields and computes the byte
// contribution of that word to its group (whole chunks, or the exact
// length on the last word). Purely combinational.
module ibi_word_decode
    import ibi_agg_pkg::*;
#(
    parameter int unsigned BYTE_W = 24
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CODE_W-1:0] code,
    output ibi_word_t         dec,
    output logic [BYTE_W-1:0] contrib
);
    localparam int unsigned PROD_W = CHK_W + CSIZE_W;

    logic [CSIZE_W-1:0] csize;
    logic [PROD_W-1:0]  prod;

    // Field extraction from the fixed bit positions.
    always_comb begin
        dec.err    = word[ERR_BIT];
        dec.last   = word[LAST_BIT];
        dec.addr   = word[ADDR_LSB +: ADDR_W];
        dec.chunks = word[CHK_LSB +: CHK_W];
        dec.len    = word[LEN_LSB +: LEN_W];
    end

    // Byte contribution of this word.
    always_comb begin
        csize   = chunk_bytes(code);
        prod    = PROD_W'(dec.chunks) * PROD_W'(csize);
        contrib = dec.last ? BYTE_W'(dec.len) : BYTE_W'(prod);
    end

endmodule

// File: rtl/ibi_group_accum.sv
// Module: holds the running state of the open group (error latch, fixed
// address, byte and chunk totals). It emits one registered event record
// when the last word is accepted, then clears for the next group.
// Assumes the caller asserts 'take' only for accepted words.
module ibi_group_accum
    import ibi_agg_pkg::*;
#(
    parameter int unsigned BYTE_W = 24,
    parameter int unsigned SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  ibi_word_t         w,
    input  logic [BYTE_W-1:0] contrib,
    input  logic [BYTE_W-1:0] max_bytes,
    output logic [SUM_W-1:0]  sum_nxt,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [BYTE_W-1:0] ev_bytes,
    output logic [SUM_W-1:0]  ev_chunks,
    output logic              ev_error,
    output logic              ev_oversize
);
    logic              g_err, g_aset;
    logic [ADDR_W-1:0] g_addr;
    logic [BYTE_W-1:0] g_bytes;
    logic [SUM_W-1:0]  g_chunks;

    logic              n_err, n_aset;
    logic [ADDR_W-1:0] n_addr;
    logic [BYTE_W-1:0] n_bytes;

    // Next group state including the word on the input.
    always_comb begin
        n_err  = g_err;
        n_aset = g_aset;
        n_addr = g_addr;
        if (!g_err) begin
            if (w.err) begin
                n_err = 1'b1;
            end else if (!g_aset) begin
                n_aset = 1'b1;
                n_addr = w.addr;
            end else if (w.addr != g_addr) begin
                n_err = 1'b1;
            end
        end
        n_bytes = g_bytes + contrib;
        sum_nxt = g_chunks + SUM_W'(w.chunks);
    end

    // Group state and event record registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_err       <= 1'b0;
            g_aset      <= 1'b0;
            g_addr      <= '0;
            g_bytes     <= '0;
            g_chunks    <= '0;
            ev_valid    <= 1'b0;
            ev_addr     <= '0;
            ev_bytes    <= '0;
            ev_chunks   <= '0;
            ev_error    <= 1'b0;
            ev_oversize <= 1'b0;
        end else begin
            ev_valid <= 1'b0;
            if (take) begin
                if (w.last) begin
                    ev_valid    <= 1'b1;
                    ev_addr     <= n_addr;
                    ev_bytes    <= n_bytes;
                    ev_chunks   <= sum_nxt;
                    ev_error    <= n_err;
                    ev_oversize <= (n_bytes > max_bytes);
                    g_err       <= 1'b0;
                    g_aset      <= 1'b0;
                    g_addr      <= '0;
                    g_bytes     <= '0;
                    g_chunks    <= '0;
                end else begin
                    g_err    <= n_err;
                    g_aset   <= n_aset;
                    g_addr   <= n_addr;
                    g_bytes  <= n_bytes;
                    g_chunks <= sum_nxt;
                end
            end
        end
    end

endmodule

// File: rtl/ibi_ring_ptrs.sv
// Module: status ring read position and dequeue pointer, circular chunk
// pool pointer and free-chunk credit. The pointers move only when a
// group completes. Assumes the sizes are stable outside reset.
module ibi_ring_ptrs #(
    parameter int unsigned SUM_W    = 16,
    parameter int unsigned CREDIT_W = 16,
    parameter int unsigned POOL_W   = 10,
    parameter int unsigned RING_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                last,
    input  logic [SUM_W-1:0]    grp_chunks,
    input  logic [RING_W-1:0]   ring_size,
    input  logic [POOL_W-1:0]   pool_size,
    output logic [POOL_W-1:0]   chunk_ptr,
    output logic [CREDIT_W-1:0] chunk_credit,
    output logic [RING_W-1:0]   deq_ptr
);
    localparam int unsigned ADV_W = ((SUM_W > POOL_W) ? SUM_W : POOL_W) + 1;

    logic [RING_W-1:0] rd_pos, pos_nxt;
    logic [RING_W:0]   pos_inc;
    logic [ADV_W-1:0]  adv, adv_mod;

    // Next ring position and reduced chunk pointer.
    always_comb begin
        pos_inc = {1'b0, rd_pos} + 1'b1;
        pos_nxt = (pos_inc >= {1'b0, ring_size}) ? '0 : pos_inc[RING_W-1:0];
        adv     = ADV_W'(chunk_ptr) + ADV_W'(grp_chunks);
        adv_mod = (pool_size == '0) ? '0 : (adv % ADV_W'(pool_size));
    end

    // Pointer and credit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pos       <= '0;
            deq_ptr      <= '0;
            chunk_ptr    <= '0;
            chunk_credit <= '0;
        end else if (take) begin
            rd_pos <= pos_nxt;
            if (last) begin
                deq_ptr      <= pos_nxt;
                chunk_ptr    <= POOL_W'(adv_mod);
                chunk_credit <= chunk_credit + CREDIT_W'(grp_chunks);
            end
        end
    end

endmodule

// File: rtl/ibi_seq_agg.sv
// Module: top of the in-band-interrupt status sequence aggregator. It
// accepts status words, merges each group into one event record and
// keeps the ring pointers. Assumes the configuration inputs change only
// while reset is held.
module ibi_seq_agg
    import ibi_agg_pkg::*;
#(
    parameter int unsigned BYTE_W   = 24,
    parameter int unsigned SUM_W    = 16,
    parameter int unsigned CREDIT_W = 16,
    parameter int unsigned POOL_W   = 10,
    parameter int unsigned RING_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    output logic                st_ready,
    input  logic [31:0]         st_word,
    input  logic [RING_W-1:0]   cfg_ring_size,
    input  logic [2:0]          cfg_chunk_code,
    input  logic [POOL_W-1:0]   cfg_pool_size,
    input  logic [BYTE_W-1:0]   cfg_max_bytes,
    output logic                ev_valid,
    output logic [6:0]          ev_addr,
    output logic [BYTE_W-1:0]   ev_bytes,
    output logic [SUM_W-1:0]    ev_chunks,
    output logic                ev_error,
    output logic                ev_oversize,
    output logic [POOL_W-1:0]   chunk_ptr,
    output logic [CREDIT_W-1:0] chunk_credit,
    output logic [RING_W-1:0]   status_deq_ptr
);
    logic              ready_q;
    logic              take;
    ibi_word_t         dec;
    logic [BYTE_W-1:0] contrib;
    logic [SUM_W-1:0]  sum_nxt;

    // Ready rises on the first clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign st_ready = ready_q;
    assign take     = st_valid & ready_q;

    ibi_word_decode #(.BYTE_W(BYTE_W)) u_dec (
        .word    (st_word),
        .code    (cfg_chunk_code),
        .dec     (dec),
        .contrib (contrib)
    );

    ibi_group_accum #(.BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .w           (dec),
        .contrib     (contrib),
        .max_bytes   (cfg_max_bytes),
        .sum_nxt     (sum_nxt),
        .ev_valid    (ev_valid),
        .ev_addr     (ev_addr),
        .ev_bytes    (ev_bytes),
        .ev_chunks   (ev_chunks),
        .ev_error    (ev_error),
        .ev_oversize (ev_oversize)
    );

    ibi_ring_ptrs #(
        .SUM_W    (SUM_W),
        .CREDIT_W (CREDIT_W),
        .POOL_W   (POOL_W),
        .RING_W   (RING_W)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .last         (dec.last),
        .grp_chunks   (sum_nxt),
        .ring_size    (cfg_ring_size),
        .pool_size    (cfg_pool_size),
        .chunk_ptr    (chunk_ptr),
        .chunk_credit (chunk_credit),
        .deq_ptr      (status_deq_ptr)
    );

endmodule

// File: rtl/ibi_seq_agg_chk.sv
// Checker: temporal properties of the aggregator at its ports. It is
// attached to every instance of the top module by the bind at the end.
module ibi_seq_agg_chk #(
    parameter int unsigned BYTE_W   = 24,
    parameter int unsigned SUM_W    = 16,
    parameter int unsigned CREDIT_W = 16,
    parameter int unsigned POOL_W   = 10,
    parameter int unsigned RING_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                st_valid,
    input logic                st_ready,
    input logic [31:0]         st_word,
    input logic [RING_W-1:0]   cfg_ring_size,
    input logic [POOL_W-1:0]   cfg_pool_size,
    input logic [BYTE_W-1:0]   cfg_max_bytes,
    input logic                ev_valid,
    input logic [BYTE_W-1:0]   ev_bytes,
    input logic [SUM_W-1:0]    ev_chunks,
    input logic                ev_oversize,
    input logic [POOL_W-1:0]   chunk_ptr,
    input logic [CREDIT_W-1:0] chunk_credit,
    input logic [RING_W-1:0]   status_deq_ptr
);
    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> st_ready);                                            // R1
    AST_EVENT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_word[30]) |=> ev_valid);                   // R4
    AST_NO_EVENT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && st_ready && st_word[30]) |=> !ev_valid);                 // R4
    AST_CHUNK_PTR_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pool_size != '0) |-> (chunk_ptr < cfg_pool_size));                // R7
    AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (chunk_credit == CREDIT_W'($past(chunk_credit) + CREDIT_W'(ev_chunks)))); // R8
    AST_DEQ_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ring_size != '0) |-> (status_deq_ptr < cfg_ring_size));           // R9
    AST_HOLD_BETWEEN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |-> ($stable(status_deq_ptr) && $stable(chunk_ptr) && $stable(chunk_credit))); // R9
    AST_OVERSIZE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_oversize == (ev_bytes > cfg_max_bytes)));             // R10

endmodule

bind ibi_seq_agg ibi_seq_agg_chk #(
    .BYTE_W   (BYTE_W),
    .SUM_W    (SUM_W),
    .CREDIT_W (CREDIT_W),
    .POOL_W   (POOL_W),
    .RING_W   (RING_W)
) u_chk (.*);

// File: tb/ibi_seq_agg_bench.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output on each falling edge.
module ibi_seq_agg_bench;
    localparam int BYTE_W = 24, SUM_W = 16, CREDIT_W = 16, POOL_W = 10, RING_W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                st_valid = 1'b0;
    logic                st_ready;
    logic [31:0]         st_word = '0;
    logic [RING_W-1:0]   cfg_ring_size = 8'd8;
    logic [2:0]          cfg_chunk_code = 3'd2;
    logic [POOL_W-1:0]   cfg_pool_size = 10'd10;
    logic [BYTE_W-1:0]   cfg_max_bytes = 24'd100;
    logic                ev_valid, ev_error, ev_oversize;
    logic [6:0]          ev_addr;
    logic [BYTE_W-1:0]   ev_bytes;
    logic [SUM_W-1:0]    ev_chunks;
    logic [POOL_W-1:0]   chunk_ptr;
    logic [CREDIT_W-1:0] chunk_credit;
    logic [RING_W-1:0]   status_deq_ptr;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    ibi_seq_agg #(
        .BYTE_W(BYTE_W), .SUM_W(SUM_W), .CREDIT_W(CREDIT_W),
        .POOL_W(POOL_W), .RING_W(RING_W)
    ) u_ibi_seq_agg (.*);

    // Reference model state.
    int m_ready, m_err, m_aset, m_addr, m_bytes, m_chunks, m_pos;
    int m_ev, m_eaddr, m_ebytes, m_echunks, m_eerr, m_eover, m_cptr, m_credit, m_deq;

    // Model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ready = 0; m_err = 0; m_aset = 0; m_addr = 0; m_bytes = 0; m_chunks = 0;
            m_pos = 0; m_ev = 0; m_eaddr = 0; m_ebytes = 0; m_echunks = 0; m_eerr = 0;
            m_eover = 0; m_cptr = 0; m_credit = 0; m_deq = 0;
        end else begin
            m_ev = 0;
            if (st_valid && m_ready == 1) begin
                int e, l, a, c, n, cs;
                e = st_word[31]; l = st_word[30]; a = st_word[29:23];
                c = st_word[22:16]; n = st_word[15:0];
                cs = (cfg_chunk_code > 6) ? 256 : (1 << (cfg_chunk_code + 2));
                if (m_err == 0) begin
                    if (e == 1) m_err = 1;
                    else if (m_aset == 0) begin m_aset = 1; m_addr = a; end
                    else if (a != m_addr) m_err = 1;
                end
                m_chunks += c;
                m_bytes += (l == 1) ? n : c * cs;
                m_pos = (m_pos + 1 >= cfg_ring_size) ? 0 : m_pos + 1;
                if (l == 1) begin
                    m_ev = 1; m_eaddr = m_addr; m_ebytes = m_bytes; m_echunks = m_chunks;
                    m_eerr = m_err; m_eover = (m_bytes > cfg_max_bytes) ? 1 : 0;
                    m_cptr = (cfg_pool_size == 0) ? 0 : (m_cptr + m_chunks) % cfg_pool_size;
                    m_credit = (m_credit + m_chunks) % 65536;
                    m_deq = m_pos;
                    m_err = 0; m_aset = 0; m_addr = 0; m_bytes = 0; m_chunks = 0;
                end
            end
            m_ready = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        chk("R1 st_ready", 32'(st_ready), 32'(m_ready));
        chk("R4 R11 ev_valid", 32'(ev_valid), 32'(m_ev));
        chk("R7 chunk_ptr", 32'(chunk_ptr), 32'(m_cptr));
        chk("R8 chunk_credit", 32'(chunk_credit), 32'(m_credit));
        chk("R9 status_deq_ptr", 32'(status_deq_ptr), 32'(m_deq));
        if (m_ev == 1) begin
            chk("R5 ev_addr", 32'(ev_addr), 32'(m_eaddr));
            chk("R2 R3 ev_bytes", 32'(ev_bytes), 32'(m_ebytes));
            chk("R7 ev_chunks", 32'(ev_chunks), 32'(m_echunks));
            chk("R5 R6 ev_error", 32'(ev_error), 32'(m_eerr));
            chk("R10 ev_oversize", 32'(ev_oversize), 32'(m_eover));
        end
    end

    function automatic logic [31:0] mk(input bit e, input bit l, input int a, input int c, input int n);
        return {e, l, 7'(a), 7'(c), 16'(n)};
    endfunction

    // Offer one word for one cycle; starts and ends just after a falling edge.
    task automatic put(input logic [31:0] w);
        st_valid = 1'b1; st_word = w;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input int ring, input int code, input int pool, input int maxb);
        rst_n = 1'b0;
        cfg_ring_size = RING_W'(ring); cfg_chunk_code = 3'(code);
        cfg_pool_size = POOL_W'(pool); cfg_max_bytes = BYTE_W'(maxb);
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        restart(8, 2, 10, 100);                                   // R1 reset state
        put(mk(0, 0, 5, 2, 0)); put(mk(0, 1, 5, 1, 7));           // R3: 2*16+7
        put(mk(0, 0, 5, 1, 0)); idle(5); put(mk(0, 1, 5, 0, 3));  // R4 pending over idle
        put(mk(0, 0, 5, 1, 0)); put(mk(0, 1, 6, 1, 1));           // R5 mismatch
        put(mk(1, 0, 9, 1, 0)); put(mk(0, 0, 3, 1, 0)); put(mk(0, 1, 4, 0, 2)); // R6 address 0
        put(mk(0, 0, 3, 1, 0)); put(mk(1, 0, 3, 1, 0)); put(mk(0, 1, 4, 1, 2)); // R6 keeps 3
        put(mk(0, 0, 2, 7, 0)); put(mk(0, 1, 2, 0, 0));           // R10 112 > 100
        put(mk(0, 0, 2, 6, 0)); put(mk(0, 1, 2, 0, 4));           // R10 exactly 100
        put(mk(1, 1, 1, 2, 5)); put(mk(0, 1, 8, 2, 6)); put(mk(0, 1, 9, 3, 7)); // R11 back to back
        idle(3);
        for (int code = 0; code < 8; code++) begin                // R2 every code
            restart(8, code, 10, 1000);
            put(mk(0, 0, 1, 3, 0)); put(mk(0, 1, 1, 1, 9));
            idle(2);
        end
        restart(3, 0, 3, 50);                                     // R7 R9 small wraps
        for (int k = 0; k < 12; k++) begin
            put(mk(0, 0, 2, k + 4, 0)); put(mk(0, 1, 2, k, k));
        end
        idle(2);
        restart(0, 1, 0, 50);                                     // R7 R9 zero sizes
        put(mk(0, 0, 2, 5, 0)); put(mk(0, 1, 2, 3, 1));
        idle(2);
        restart(255, 6, 1023, 40000);                             // R8 credit wrap
        for (int k = 0; k < 530; k++) put(mk(0, 1, 4, 127, k));
        idle(2);
        restart(7, 3, 37, 300);                                   // mixed stream
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom;
            if (r[2:0] == 3'd0) idle(1);
            put(mk(r[7:5] == 3'd0, r[9:8] == 2'd0, 1 + r[10], r[16:11] % 9, r[31:20]));
        end
        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule